// File: doc/BRIEF.md
# Init Handshake and SPI Ownership Controller

This block sits between a host register bus and an embedded configuration engine that shares one SPI master with the host. After power-up the embedded side owns the SPI master. The host asks for a single retimer configuration by writing one init word. That word carries a start flag and a 2-bit forward-error-correction request for each of eight links: four on port A and four on port B. The block models the configuration run as a programmable cycle delay. When the delay ends it raises a done flag, fills two per-port mode status words, and then moves an ownership select so that the SPI master is handed to the host.

The configuration is taken once per power-up. The reset of the block stands for power-up. Once start or done is set, every further write to the init word is dropped. A read-only version word reports the firmware build. A build parameter of zero means that no firmware is present. In that case the host owns the SPI master from reset and no configuration ever runs.

Top module: `init_handshake_ctrl`

## Requirements
- R1: After reset with firmware present, `host_own` is 0, and reads of the init word (0x1000) and of both status words (0x1020, 0x1024) return 0.
- R2: A read pulse on `bus_rd` returns data on `bus_rdata` with `bus_rvalid` high one clock later. Address 0x1004 returns `FW_VERSION` (major in bits 31:28, minor in 27:24, patch in 23:20). Any unmapped address reads as 0.
- R3: A write to 0x1000 with bit 1 (start) set is accepted and latches bits 23:8 as eight 2-bit link requests. The fields are A0 at 9:8, rising through A3 at 15:14, then B0 at 17:16 through B3 at 23:22. The codes are 0 for no FEC, 1 for fire-code FEC and 2 for Reed-Solomon. A read then returns the latched fields, bit 1 set and bit 0 (done) clear.
- R4: Before a configuration is accepted, a write to 0x1000 with bit 1 clear changes nothing, and the init word still reads 0.
- R5: While start or done is set, writes to 0x1000 are ignored: the mode fields and the flags keep their values until reset.
- R6: Done becomes 1 exactly `CFG_DELAY` clock edges after the edge that accepts the start write. `host_own` rises on the following edge and stays 1 until reset.
- R7: At the edge where done sets, 0x1020 takes the value {`STS_GROUP` in 15:8, the port A link fields (A3..A0, 2 bits each) in 7:0}. 0x1024 takes the same form with the port B fields.
- R8: With `FW_VERSION` = 0, `host_own` is 1 after reset, start writes are ignored, and the init word keeps reading 0.
- R9: Reset clears the lock, so a new configuration with different mode fields is accepted after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| host_own | output | 1 | SPI master select: 0 embedded engine, 1 host |

## Verification
The bench attacks the one-time lock from both sides. It sends a write without start before any configuration and sends fresh requests both during the run and after done. A design with a loose lock would show the new mode bits on readback. It measures the ownership hand-over to the exact edge, which catches a counter that is off by one or an ownership select that is not registered. It checks the status words for swapped port halves, and it checks that reset reopens the lock. A second instance built with no firmware confirms that the host owns the SPI master at once and that start writes are dropped.

// File: rtl/ihs_pkg.sv
`timescale 1ns/1ps
package ihs_pkg;
  localparam int unsigned IHS_OFS_INIT   = 32'h1000;
  localparam int unsigned IHS_OFS_VER    = 32'h1004;
  localparam int unsigned IHS_OFS_STS_A  = 32'h1020;
  localparam int unsigned IHS_OFS_STS_B  = 32'h1024;
  localparam int unsigned IHS_DONE_BIT   = 0;
  localparam int unsigned IHS_START_BIT  = 1;
  localparam int unsigned IHS_MODE_LSB   = 8;
  localparam int unsigned IHS_GROUP_W    = 8;
  localparam int unsigned IHS_ID_W       = 8;

  typedef enum logic {
    OWN_EMBEDDED = 1'b0,
    OWN_HOST     = 1'b1
  } owner_e;
endpackage

// File: rtl/ihs_cfg_lock.sv
`timescale 1ns/1ps
module ihs_cfg_lock #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_LINKS = 8,
  parameter int unsigned MODE_W    = 2,
  parameter bit          HAS_FW    = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        done_i,
  output logic                        start_o,
  output logic [NUM_LINKS*MODE_W-1:0] modes_o
);
  import ihs_pkg::*;

  localparam logic [ADDR_W-1:0] INIT_ADDR = ADDR_W'(IHS_OFS_INIT);

  logic accept;
  // one-shot acceptance: only a start-setting write to a free, firmware-backed block
  assign accept = HAS_FW && wr_en && (wr_addr == INIT_ADDR) &&
                  wr_data[IHS_START_BIT] && !start_o && !done_i;

  always_ff @(posedge clk) begin
    if (rst) start_o <= 1'b0;
    else if (accept) start_o <= 1'b1;
  end

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
    logic [MODE_W-1:0] req_q;
    always_ff @(posedge clk) begin
      if (rst) req_q <= '0;
      else if (accept) req_q <= wr_data[IHS_MODE_LSB + g*MODE_W +: MODE_W];
    end
    assign modes_o[g*MODE_W +: MODE_W] = req_q;
  end
endmodule

// File: rtl/ihs_seq.sv
`timescale 1ns/1ps
module ihs_seq #(
  parameter int unsigned NUM_LINKS = 8,
  parameter int unsigned MODE_W    = 2,
  parameter int unsigned CFG_DELAY = 1000,
  parameter logic [7:0]  STS_GROUP = 8'h01
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start_i,
  input  logic [NUM_LINKS*MODE_W-1:0] modes_i,
  output logic                        done_o,
  output logic [15:0]                 sts_a_o,
  output logic [15:0]                 sts_b_o
);
  import ihs_pkg::*;

  localparam int unsigned PORT_BITS = (NUM_LINKS / 2) * MODE_W;
  localparam int unsigned CNT_W     = (CFG_DELAY > 1) ? $clog2(CFG_DELAY) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CFG_DELAY - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             running;
  logic             finish;

  assign running = start_i && !done_o;
  assign finish  = running && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (finish) begin
      done_o <= 1'b1;
    end else if (running) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_a_o <= '0;
      sts_b_o <= '0;
    end else if (finish) begin
      sts_a_o <= {STS_GROUP, IHS_ID_W'(modes_i[PORT_BITS-1:0])};
      sts_b_o <= {STS_GROUP, IHS_ID_W'(modes_i[2*PORT_BITS-1:PORT_BITS])};
    end
  end
endmodule

// File: rtl/ihs_rd_mux.sv
`timescale 1ns/1ps
module ihs_rd_mux #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_LINKS  = 8,
  parameter int unsigned MODE_W     = 2,
  parameter logic [31:0] FW_VERSION = 32'h3150_0000
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           rd_addr,
  input  logic                        start_i,
  input  logic                        done_i,
  input  logic [NUM_LINKS*MODE_W-1:0] modes_i,
  input  logic [15:0]                 sts_a_i,
  input  logic [15:0]                 sts_b_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic                        rvalid_o
);
  import ihs_pkg::*;

  logic [DATA_W-1:0] init_word;
  logic [DATA_W-1:0] sel_word;

  always_comb begin
    init_word = '0;
    init_word[IHS_MODE_LSB +: NUM_LINKS*MODE_W] = modes_i;
    init_word[IHS_START_BIT] = start_i;
    init_word[IHS_DONE_BIT]  = done_i;
  end

  always_comb begin
    unique case (rd_addr)
      ADDR_W'(IHS_OFS_INIT):  sel_word = init_word;
      ADDR_W'(IHS_OFS_VER):   sel_word = DATA_W'(FW_VERSION);
      ADDR_W'(IHS_OFS_STS_A): sel_word = DATA_W'(sts_a_i);
      ADDR_W'(IHS_OFS_STS_B): sel_word = DATA_W'(sts_b_i);
      default:                sel_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en;
      if (rd_en) rdata_o <= sel_word;
    end
  end
endmodule

// File: rtl/init_handshake_ctrl.sv
`timescale 1ns/1ps
module init_handshake_ctrl #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_LINKS  = 8,
  parameter int unsigned MODE_W     = 2,
  parameter int unsigned CFG_DELAY  = 1000,
  parameter logic [31:0] FW_VERSION = 32'h3150_0000,
  parameter logic [7:0]  STS_GROUP  = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              host_own
);
  import ihs_pkg::*;

  localparam bit HAS_FW = (FW_VERSION != 32'h0);

  logic                        cfg_start;
  logic                        cfg_done;
  logic [NUM_LINKS*MODE_W-1:0] cfg_modes;
  logic [15:0]                 sts_a;
  logic [15:0]                 sts_b;
  owner_e                      owner_q;

  ihs_cfg_lock #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LINKS(NUM_LINKS),
    .MODE_W(MODE_W), .HAS_FW(HAS_FW)
  ) u_lock (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .done_i(cfg_done),
    .start_o(cfg_start), .modes_o(cfg_modes)
  );

  ihs_seq #(
    .NUM_LINKS(NUM_LINKS), .MODE_W(MODE_W),
    .CFG_DELAY(CFG_DELAY), .STS_GROUP(STS_GROUP)
  ) u_seq (
    .clk(clk), .rst(rst), .start_i(cfg_start), .modes_i(cfg_modes),
    .done_o(cfg_done), .sts_a_o(sts_a), .sts_b_o(sts_b)
  );

  ihs_rd_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LINKS(NUM_LINKS),
    .MODE_W(MODE_W), .FW_VERSION(FW_VERSION)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .rd_addr(bus_addr),
    .start_i(cfg_start), .done_i(cfg_done), .modes_i(cfg_modes),
    .sts_a_i(sts_a), .sts_b_i(sts_b),
    .rdata_o(bus_rdata), .rvalid_o(bus_rvalid)
  );

  // ownership select: registered, handed to the host once and kept
  always_ff @(posedge clk) begin
    if (rst) owner_q <= HAS_FW ? OWN_EMBEDDED : OWN_HOST;
    else if (cfg_done) owner_q <= OWN_HOST;
  end

  assign host_own = (owner_q == OWN_HOST);
endmodule

// File: rtl/ihs_chk.sv
`timescale 1ns/1ps
module ihs_chk #(
  parameter int unsigned MW     = 16,
  parameter bit          HAS_FW = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          done,
  input logic [MW-1:0] modes,
  input logic          host_own,
  input logic          bus_rd,
  input logic          bus_rvalid
);
  // R2
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  // R5
  modes_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> $stable(modes));

  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  // R6
  done_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> start);

  // R6
  done_to_host_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> host_own);

  // R6
  host_kept_chk: assert property (@(posedge clk) disable iff (rst)
    host_own |=> host_own);

  // R8
  nofw_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !HAS_FW |-> (!start && !done && host_own));
endmodule

bind init_handshake_ctrl ihs_chk #(
  .MW(NUM_LINKS*MODE_W), .HAS_FW(HAS_FW)
) u_chk (
  .clk(clk), .rst(rst), .start(cfg_start), .done(cfg_done),
  .modes(cfg_modes), .host_own(host_own),
  .bus_rd(bus_rd), .bus_rvalid(bus_rvalid)
);

// File: tb/init_handshake_ctrl_tb.sv
`timescale 1ns/1ps
module init_handshake_ctrl_tb;
  localparam int unsigned DLY  = 8;
  localparam logic [31:0] VER  = 32'h3150_0000;
  localparam logic [7:0]  GRP  = 8'h3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata, rdata_nf;
  logic        rvalid, rvalid_nf;
  logic        own, own_nf;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  init_handshake_ctrl #(.CFG_DELAY(DLY), .FW_VERSION(VER), .STS_GROUP(GRP)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .bus_rvalid(rvalid), .host_own(own));

  init_handshake_ctrl #(.CFG_DELAY(DLY), .FW_VERSION(32'h0), .STS_GROUP(GRP)) u_nofw (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_nf), .bus_rvalid(rvalid_nf), .host_own(own_nf));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk); bus_rd = 1'b0;
    d = rdata;
    check("R2 rvalid", {31'b0, rvalid}, 32'h1);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    do_reset();
    check("R1 host_own after reset", {31'b0, own}, 32'h0);
    rd(16'h1000, v); check("R1 init word", v, 32'h0);
    rd(16'h1020, v); check("R1 status A", v, 32'h0);
    rd(16'h1024, v); check("R1 status B", v, 32'h0);
  endtask

  task automatic t_version_unmapped();
    logic [31:0] v;
    rd(16'h1004, v); check("R2 version", v, VER);
    rd(16'h1008, v); check("R2 unmapped 0x1008", v, 32'h0);
    rd(16'h0000, v); check("R2 unmapped 0x0000", v, 32'h0);
  endtask

  task automatic t_no_start_ignored();
    logic [31:0] v;
    wr(16'h1000, 32'h00AA_AA00);
    rd(16'h1000, v); check("R4 write without start", v, 32'h0);
    check("R4 host_own unchanged", {31'b0, own}, 32'h0);
  endtask

  task automatic t_first_config();
    logic [31:0] v;
    wr(16'h1000, 32'h0025_8602);
    repeat (DLY) @(posedge clk);
    @(negedge clk);
    check("R6 host_own still 0 at done edge", {31'b0, own}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R6 host_own one edge after done", {31'b0, own}, 32'h1);
    rd(16'h1000, v); check("R3 R6 init after done", v, 32'h0025_8603);
    rd(16'h1020, v); check("R7 status A", v, {16'h0, GRP, 8'h86});
    rd(16'h1024, v); check("R7 status B", v, {16'h0, GRP, 8'h25});
  endtask

  task automatic t_relock_after_done();
    logic [31:0] v;
    wr(16'h1000, 32'h00FF_FF02);
    wr(16'h1000, 32'h0000_0000);
    rd(16'h1000, v); check("R5 writes after done ignored", v, 32'h0025_8603);
    repeat (20) @(negedge clk);
    check("R6 host_own kept", {31'b0, own}, 32'h1);
  endtask

  task automatic t_second_powerup();
    logic [31:0] v;
    do_reset();
    check("R9 host_own back to embedded", {31'b0, own}, 32'h0);
    wr(16'h1000, 32'h0055_5502);
    rd(16'h1000, v); check("R3 R9 accepted after reset", v, 32'h0055_5502);
    wr(16'h1000, 32'h00AA_AA02);
    rd(16'h1000, v); check("R5 write during run ignored", v, 32'h0055_5502);
    repeat (DLY + 2) @(negedge clk);
    check("R6 host_own after second run", {31'b0, own}, 32'h1);
    rd(16'h1000, v); check("R3 init done all fire-code", v, 32'h0055_5503);
    rd(16'h1020, v); check("R7 status A fire-code", v, {16'h0, GRP, 8'h55});
  endtask

  task automatic t_no_firmware();
    check("R8 host owns with no firmware", {31'b0, own_nf}, 32'h1);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 16'h1000;
    @(posedge clk); @(negedge clk); bus_rd = 1'b0;
    check("R8 init word stays 0", rdata_nf, 32'h0);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 16'h1004;
    @(posedge clk); @(negedge clk); bus_rd = 1'b0;
    check("R8 version reads 0", rdata_nf, 32'h0);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_version_unmapped();
    t_no_start_ignored();
    t_first_config();
    t_relock_after_done();
    t_no_firmware();
    t_second_powerup();
    t_no_firmware();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule